// File: doc/BRIEF.md
# Run-Length Group Prefix Remapping Translator

This block sits in front of a run-length decompressor whose codewords are a unary group prefix followed by a tail. In the natural code, group g is announced by g-1 ones and a closing 0, and then g tail bits follow. An encoder may instead hand out the short prefixes to whichever groups occur most often. The translator undoes that choice. It counts the leading ones of each received prefix to get a rank, and looks that rank up in a small programmable table to get the canonical group. It then emits the canonical prefix and forwards exactly as many tail bits as the canonical group requires. The downstream decoder therefore always sees prefixes in natural group order.

The input and output are single-bit streams with valid/ready handshakes. While the translated prefix is being emitted, the input is stalled, because that prefix may be longer than the one received. The table holds one entry per rank and resets to the identity mapping, so after reset the block passes data through unchanged. Software may rewrite an entry only while the block sits between codewords.

Top module: `prefix_remap_xlate`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and every table entry maps rank r to group r.
- R2: A received prefix of k ones closed by a 0 has rank k+1. Bits accepted while a prefix is being received produce no output (out_valid stays 0).
- R3: Once the closing 0 is accepted, the block emits g-1 ones followed by one 0, where g is the table entry for the rank. in_ready is 0 throughout this emission.
- R4: After the emitted 0, exactly g tail bits pass from input to output unchanged. During this phase out_valid follows in_valid and in_ready follows out_ready. The next accepted bit then starts a new prefix.
- R5: With the identity table, the output bit stream equals the input bit stream for every rank from 1 to NUM_GROUPS.
- R6: A write with map_wr_en=1 is taken only when no prefix bit has been received yet. Both map_wr_rank and map_wr_group must lie in 1..NUM_GROUPS. The new group then applies to that rank. In a cycle where a write is requested at idle, in_ready is 0.
- R7: A write requested while a prefix is partly received, or with a rank or group of 0 or above NUM_GROUPS, leaves the table unchanged.
- R8: Leading ones beyond NUM_GROUPS-1 are consumed and ignored, so the prefix is treated as rank NUM_GROUPS when its 0 arrives.
- R9: While the block emits a prefix bit and out_ready is 0, out_valid and out_bit hold steady.
- R10: With rank 1 mapped to group 3, rank 2 to group 1 and rank 3 to group 2, a received 0 becomes 110, a received 10 becomes 0 and a received 110 becomes 10. Each tail keeps its canonical length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Encoded input bit is valid |
| in_ready | output | 1 | Translator accepts the input bit |
| in_bit | input | 1 | Encoded input bit |
| out_valid | output | 1 | Translated output bit is valid |
| out_ready | input | 1 | Downstream decoder accepts the output bit |
| out_bit | output | 1 | Translated output bit |
| map_wr_en | input | 1 | Table write request |
| map_wr_rank | input | $clog2(NUM_GROUPS+1) | Received rank (1-based) to rewrite |
| map_wr_group | input | $clog2(NUM_GROUPS+1) | Canonical group (1-based) for that rank |

## Verification
The bench pushes codewords of every rank under random gaps on both handshakes. It checks each output bit against a stream computed from a behavioural table. A design that took the tail length from the received rank instead of the remapped group would slip every later codeword, and those bits would mismatch. A table write aimed at a half-received prefix, and writes with out-of-range fields, are followed by codewords that expose any entry that wrongly changed. An over-long run of leading ones checks that the rank saturates instead of wrapping into a short group. Output bits that appear while nothing is owed, or input accepted during prefix emission, are flagged cycle by cycle.

// File: rtl/prefix_remap_pkg.sv
// Shared types for the prefix remapping translator.
// Assumes: nothing beyond standard SystemVerilog.
package prefix_remap_pkg;

    // Phase of the codeword currently in flight.
    typedef enum logic [1:0] {
        ST_PREFIX = 2'd0,   // counting leading ones of a received prefix
        ST_EMIT   = 2'd1,   // emitting the canonical prefix
        ST_TAIL   = 2'd2    // forwarding tail bits verbatim
    } rmp_state_e;

endpackage

// File: rtl/grp_map_table.sv
// Rank-to-group lookup table, one register per rank.
// Does: resets to identity (index i holds group i+1); writes one entry per
// cycle when wr_ok is set; reads combinationally.
// Assumes: wr_ok is already qualified by the caller (idle and legal fields).
module grp_map_table #(
    parameter int NG = 10,
    parameter int GW = 4,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  logic [IW-1:0] wr_idx,
    input  logic [GW-1:0] wr_grp,
    input  logic [IW-1:0] rd_idx,
    output logic [GW-1:0] rd_grp
);

    logic [GW-1:0]    mem [NG];
    logic [NG*GW-1:0] mem_flat;

    for (genvar e = 0; e < NG; e++) begin : g_ent
        // Hold one table entry; identity value on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[e] <= GW'(e + 1);
            else if (wr_ok && wr_idx == IW'(e))
                mem[e] <= wr_grp;
        end
        assign mem_flat[e*GW +: GW] = mem[e];
    end

    // Combinational read of the entry for the current rank.
    assign rd_grp = mem[rd_idx];

    // R7
    tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(mem_flat));

    // R6
    tbl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> mem_flat[$past(wr_idx)*GW +: GW] == $past(wr_grp));

endmodule

// File: rtl/rank_counter.sv
// Saturating up-counter for the leading ones of a received prefix.
// Does: clears on clr (priority), else increments on inc until MAXV.
// Assumes: MAXV fits in W bits.
module rank_counter #(
    parameter int W    = 4,
    parameter int MAXV = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Count leading ones, holding at MAXV.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && cnt != W'(MAXV))
            cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/phase_counter.sv
// Load/decrement counter shared by prefix emission and tail forwarding.
// Does: load takes priority over dec; flags zero and one for the sequencer.
// Assumes: dec is never asserted while the count is zero.
module phase_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);

    logic [W-1:0] cnt;

    // Track bits remaining in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - W'(1);
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == W'(1));

endmodule

// File: rtl/prefix_remap_xlate.sv
// Group prefix remapping translator (top).
// Does: counts leading ones of each received prefix, maps the rank through a
// programmable table, emits the canonical unary prefix, then forwards exactly
// as many tail bits as the canonical group.
// Assumes: NUM_GROUPS >= 2; input codewords are well formed apart from
// over-long prefixes, which saturate at rank NUM_GROUPS.
module prefix_remap_xlate
    import prefix_remap_pkg::*;
#(
    parameter int NUM_GROUPS = 10
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic                                 in_bit,
    output logic                                 out_valid,
    input  logic                                 out_ready,
    output logic                                 out_bit,
    input  logic                                 map_wr_en,
    input  logic [$clog2(NUM_GROUPS+1)-1:0]      map_wr_rank,
    input  logic [$clog2(NUM_GROUPS+1)-1:0]      map_wr_group
);

    localparam int GW = $clog2(NUM_GROUPS + 1);
    localparam int IW = $clog2(NUM_GROUPS);

    rmp_state_e    state, state_nxt;
    logic [IW-1:0] ones_cnt;
    logic [GW-1:0] map_grp;
    logic [GW-1:0] grp_q;
    logic          in_hs, out_hs;
    logic          idle, wr_legal, wr_take;
    logic          pfx_end, emit_end;
    logic          ph_load, ph_dec, ph_zero, ph_one;
    logic [GW-1:0] ph_load_val;

    assign in_hs  = in_valid && in_ready;
    assign out_hs = out_valid && out_ready;

    // Idle: between codewords, no prefix bit received yet.
    assign idle     = (state == ST_PREFIX) && (ones_cnt == '0);
    assign wr_legal = (map_wr_rank  != '0) && (map_wr_rank  <= GW'(NUM_GROUPS)) &&
                      (map_wr_group != '0) && (map_wr_group <= GW'(NUM_GROUPS));
    assign wr_take  = map_wr_en && idle && wr_legal;

    assign pfx_end  = (state == ST_PREFIX) && in_hs && !in_bit;
    assign emit_end = (state == ST_EMIT) && out_hs && ph_zero;

    grp_map_table #(.NG(NUM_GROUPS), .GW(GW), .IW(IW)) tbl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ok  (wr_take),
        .wr_idx (IW'(map_wr_rank - GW'(1))),
        .wr_grp (map_wr_group),
        .rd_idx (ones_cnt),
        .rd_grp (map_grp)
    );

    rank_counter #(.W(IW), .MAXV(NUM_GROUPS - 1)) rank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pfx_end),
        .inc   ((state == ST_PREFIX) && in_hs && in_bit),
        .cnt   (ones_cnt)
    );

    // Choose what the phase counter loads and when it counts down.
    always_comb begin
        ph_load     = pfx_end || emit_end;
        ph_load_val = pfx_end ? (map_grp - GW'(1)) : grp_q;
        ph_dec      = ((state == ST_EMIT) && out_hs && !ph_zero) ||
                      ((state == ST_TAIL) && in_hs);
    end

    phase_counter #(.W(GW)) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_load_val),
        .dec      (ph_dec),
        .is_zero  (ph_zero),
        .is_one   (ph_one)
    );

    // Latch the canonical group when a prefix closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grp_q <= GW'(1);
        else if (pfx_end)
            grp_q <= map_grp;
    end

    // Next phase of the codeword.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_PREFIX: if (pfx_end) state_nxt = ST_EMIT;
            ST_EMIT:   if (emit_end) state_nxt = ST_TAIL;
            ST_TAIL:   if (in_hs && ph_one) state_nxt = ST_PREFIX;
            default:   state_nxt = ST_PREFIX;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_PREFIX;
        else
            state <= state_nxt;
    end

    // Handshake and data steering per phase.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_bit   = 1'b0;
        case (state)
            ST_PREFIX: in_ready = !(map_wr_en && ones_cnt == '0);
            ST_EMIT: begin
                out_valid = 1'b1;
                out_bit   = !ph_zero;
            end
            ST_TAIL: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_bit   = in_bit;
            end
            default: ;
        endcase
    end

    // Checker counters: ones emitted and tail bits forwarded so far.
    logic [GW-1:0] chk_ones, chk_tail;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_ones <= '0;
            chk_tail <= '0;
        end else begin
            if (state == ST_EMIT && out_hs)
                chk_ones <= out_bit ? chk_ones + GW'(1) : '0;
            if (state == ST_TAIL && in_hs)
                chk_tail <= ph_one ? '0 : chk_tail + GW'(1);
        end
    end

    // R3
    emit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && out_hs && !out_bit) |-> chk_ones == grp_q - GW'(1));

    // R4
    tail_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL && in_hs && ph_one) |-> chk_tail == grp_q - GW'(1));

    // R9
    emit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && !out_ready) |=> out_valid && $stable(out_bit));

    // R6
    write_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_wr_en && idle) |-> !in_ready);

endmodule

// File: tb/prefix_remap_xlate_tb.sv
// Bench for prefix_remap_xlate: behavioural stream model compared every clock.
module prefix_remap_xlate_tb_top;

    localparam int NG      = 10;
    localparam int GW      = $clog2(NG + 1);
    localparam int CLK_PER = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready, in_bit;
    logic out_valid, out_ready, out_bit;
    logic map_wr_en;
    logic [GW-1:0] map_wr_rank, map_wr_group;

    always #(CLK_PER/2) clk = ~clk;

    prefix_remap_xlate #(.NUM_GROUPS(NG)) dut_i (
        .clk, .rst_n, .in_valid, .in_ready, .in_bit,
        .out_valid, .out_ready, .out_bit,
        .map_wr_en, .map_wr_rank, .map_wr_group
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    string scen = "R1";

    int  model_map [1:NG];
    bit  in_q  [$];
    bit  exp_b [$];
    bit  exp_p [$];   // 1 = prefix bit, 0 = tail bit

    task automatic check(bit ok, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", scen, what, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int r = 1; r <= NG; r++) model_map[r] = r;
    endtask

    // Push one codeword of rank 'rank' with 'extra' surplus leading ones.
    task automatic add_word(int rank, int extra);
        int g = model_map[rank];
        for (int i = 0; i < rank - 1 + extra; i++) in_q.push_back(1'b1);
        in_q.push_back(1'b0);
        for (int i = 0; i < g - 1; i++) begin exp_b.push_back(1'b1); exp_p.push_back(1'b1); end
        exp_b.push_back(1'b0); exp_p.push_back(1'b1);
        for (int i = 0; i < g; i++) begin
            bit t = 1'($urandom);
            in_q.push_back(t);
            exp_b.push_back(t); exp_p.push_back(1'b0);
        end
    endtask

    // Drive stream with random gaps until only stop_at input bits remain.
    task automatic run(bit wait_out, int stop_at);
        while (in_q.size() > stop_at || (wait_out && exp_b.size() > 0)) begin
            @(negedge clk);
            in_valid  = (in_q.size() > stop_at) && ($urandom % 4 != 0);
            in_bit    = (in_q.size() > 0) ? in_q[0] : 1'b0;
            out_ready = ($urandom % 3 != 0);
            #1;
            if (out_valid) begin
                // R2: nothing owed means no output
                check(exp_b.size() > 0, "R2 unexpected output", 1, 0);
                // R3: input stalled during prefix emission
                if (exp_b.size() > 0 && exp_p[0])
                    check(!in_ready, "R3 in_ready during emit", int'(in_ready), 0);
            end
            if (out_valid && out_ready && exp_b.size() > 0) begin
                check(out_bit == exp_b[0], exp_p[0] ? "R3 prefix bit" : "R4 tail bit",
                      int'(out_bit), int'(exp_b[0]));
                void'(exp_b.pop_front());
                void'(exp_p.pop_front());
            end
            if (in_valid && in_ready) void'(in_q.pop_front());
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        #1;
        if (exp_b.size() == 0)
            check(!out_valid, "R2 output after drain", int'(out_valid), 0);
    endtask

    task automatic tbl_write(int rank, int grp, bit idle);
        @(negedge clk);
        map_wr_en    = 1'b1;
        map_wr_rank  = GW'(rank);
        map_wr_group = GW'(grp);
        #1;
        // R6 stall at idle; R7 no stall mid-prefix
        check(in_ready == !idle, idle ? "R6 in_ready on write" : "R7 in_ready on busy write",
              int'(in_ready), int'(!idle));
        @(negedge clk);
        map_wr_en = 1'b0;
        if (idle && rank >= 1 && rank <= NG && grp >= 1 && grp <= NG)
            model_map[rank] = grp;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        in_q.delete(); exp_b.delete(); exp_p.delete();
    endtask

    initial begin
        in_valid = 0; in_bit = 0; out_ready = 0;
        map_wr_en = 0; map_wr_rank = '0; map_wr_group = '0;
        do_reset();
        #1;
        scen = "R1";
        check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready,   "R1 in_ready after reset",  int'(in_ready), 1);

        // R5: identity table is transparent for every rank
        scen = "R5";
        for (int r = 1; r <= NG; r++) add_word(r, 0);
        run(1, 0);

        // R10: worked remapping example
        scen = "R10";
        tbl_write(1, 3, 1);
        tbl_write(2, 1, 1);
        tbl_write(3, 2, 1);
        add_word(1, 0); add_word(2, 0); add_word(3, 0); add_word(1, 0);
        run(1, 0);

        // R6: a longer remap, long group to short rank and back
        scen = "R6";
        tbl_write(4, NG, 1);
        tbl_write(NG, 1, 1);
        for (int k = 0; k < 3; k++) begin add_word(4, 0); add_word(NG, 0); end
        run(1, 0);

        // R7: illegal field writes are ignored
        scen = "R7";
        tbl_write(0, 2, 1);
        tbl_write(2, 0, 1);
        tbl_write(2, NG + 1, 1);
        tbl_write(NG + 1, 2, 1);
        add_word(2, 0); add_word(1, 0);
        run(1, 0);

        // R7: write attempted while a prefix is half received
        add_word(2, 0);
        run(0, in_q.size() - 1);
        tbl_write(2, 7, 0);
        run(1, 0);
        add_word(2, 0);
        run(1, 0);

        // R8: over-long prefix saturates at rank NG
        scen = "R8";
        add_word(NG, 3);
        add_word(1, 0);
        run(1, 0);

        // R1: reset restores identity mapping
        do_reset();
        scen = "R1";
        add_word(1, 0); add_word(3, 0); add_word(NG, 0);
        run(1, 0);

        // R9/R4: random mix under heavy back-pressure
        scen = "R9";
        tbl_write(1, 2, 1);
        tbl_write(2, 1, 1);
        for (int k = 0; k < 40; k++) add_word(1 + ($urandom % NG), 0);
        run(1, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired in %s", scen);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule